// File: doc/BRIEF.md
# NAND Flash Host Register Interface

This block sits between a simple processor register port and a raw 8-bit NAND flash device that software drives by hand. Software writes a control register whose bits go straight to the NAND chip-enable, command-latch, address-latch and write-protect pins. Command, address and data bytes are then moved through a single data register: a write sends the byte to the NAND with a one-cycle write strobe, and a read pulls a byte from the NAND with a one-cycle read strobe.

Every byte crossing the data register in either direction is also fed into an error-correction accumulator. The accumulator keeps two 8-bit line-parity words indexed by the byte's position in a 256-byte block, six column-parity bits and a byte counter. Software reads these back through dedicated registers, where the two line-parity words appear bit-interleaved, and zeroes them all by writing a clear register. A 32-bit read of the data register fetches two NAND bytes in one request.

Requests are accepted one at a time while `req_ready` is high; each produces exactly one `rsp_valid` pulse carrying the read data.

Top module: `nfh_regif`

## Requirements
- R1: After reset all NAND control outputs and strobes are low, `req_ready` is high, `rsp_valid` is low, and the byte counter, both parity readouts and column parity read 0.
- R2: A write to offset 0x18 stores wdata[7:0] with bit 5 forced to 0; outputs follow the stored bits from the next cycle: `nand_cle` = bit 1, `nand_ale` = bit 2, `nand_wp` = bit 3, `nand_ce` = bit 0 OR bit 4.
- R3: A read of offset 0x18 returns the stored bits in rdata[7:0] with bit 5 replaced by the level of `nand_rb` sampled in the accept cycle; all higher bits are 0.
- R4: A write to offset 0x14 places wdata[7:0] on `nand_dout` and pulses `nand_wr_stb` for exactly one cycle, the cycle after acceptance; `rsp_valid` appears in that same cycle.
- R5: A byte read (req_wide=0) of offset 0x14 pulses `nand_rd_stb` once, in the cycle after acceptance, and returns the byte present on `nand_din` in that cycle in rdata[7:0] with all other bits 0; `rsp_valid` follows one cycle later.
- R6: A wide read (req_wide=1) of offset 0x14 pulses `nand_rd_stb` in two consecutive cycles; the first byte lands in rdata[7:0], the second in rdata[23:16], all other bits are 0, and `rsp_valid` comes the cycle after the second strobe.
- R7: Offset 0x0C reads the number of bytes moved through offset 0x14 since the last clear, modulo 256, counting written and read bytes alike.
- R8: For each digested byte with an odd number of set bits, internal word A is XORed with the inverted block index and word B with the index, where the index is the counter value before the byte. Offset 0x00 returns A[4+k] at bit 2k and B[4+k] at bit 2k+1 (k=0..3); offset 0x04 returns A[k] at bit 2k and B[k] at bit 2k+1.
- R9: Offset 0x08 returns in bits 5:0 the running XOR of six per-byte column parities: bit 0 over data bits 0,2,4,6; bit 1 over 1,3,5,7; bit 2 over 0,1,4,5; bit 3 over 2,3,6,7; bit 4 over 0..3; bit 5 over 4..7. Bits 7:6 read 0.
- R10: A write of any value to offset 0x10 zeroes the counter, both line-parity words and the column parity, and leaves the control register unchanged.
- R11: Reads of offset 0x10, of offsets 0x1C to 0x3F, and of any offset not a multiple of 4 return 0; writes to those offsets and to 0x00, 0x04, 0x08 and 0x0C change no output, no register and generate no strobe.
- R12: `req_ready` is low while a NAND read is in progress (in every cycle where `nand_rd_stb` is high) and each request yields exactly one `rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit access |
| req_addr | input | 6 | Byte offset within the register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| nand_ce | output | 1 | Chip enable (either enable bit set) |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_wp | output | 1 | Write protect |
| nand_rb | input | 1 | Live ready/busy level from the device |
| nand_dout | output | 8 | Byte driven to the device |
| nand_wr_stb | output | 1 | One-cycle write strobe |
| nand_din | input | 8 | Byte from the device |
| nand_rd_stb | output | 1 | One-cycle read strobe |

## Verification
The bench builds the block with its default parameters: a 6-bit offset, 32-bit data, 8-bit bytes and a 256-byte parity block. With an 8-bit block index, pushing a little over 300 bytes through the data register is enough to wrap the counter and the parity index, so the modulo-256 boundary of the counter and the line parity is reached without long runs. The 32-bit data width places the second fetched byte at bits 23:16, which the wide reads exercise against a behavioural NAND model that streams a computed byte sequence.

// File: rtl/nfh_pkg.sv
package nfh_pkg;

    // Register offsets (byte addresses inside the window)
    localparam int OFS_LP_HI = 'h00;
    localparam int OFS_LP_LO = 'h04;
    localparam int OFS_COLP  = 'h08;
    localparam int OFS_CNT   = 'h0C;
    localparam int OFS_CLR   = 'h10;
    localparam int OFS_DATA  = 'h14;
    localparam int OFS_CTL   = 'h18;

    // Control register bit positions
    localparam int CTL_CE0 = 0;
    localparam int CTL_CLE = 1;
    localparam int CTL_ALE = 2;
    localparam int CTL_WP  = 3;
    localparam int CTL_CE1 = 4;
    localparam int CTL_RB  = 5;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RD_FIRST  = 2'd1,
        ST_RD_SECOND = 2'd2
    } nfh_state_e;

endpackage

// File: rtl/nfh_ecc_acc.sv
module nfh_ecc_acc #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 8,
    parameter int CP_W   = 2 * $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              valid,
    input  logic [BYTE_W-1:0] din,
    output logic [IDX_W-1:0]  lp_a,
    output logic [IDX_W-1:0]  lp_b,
    output logic [CP_W-1:0]   cp,
    output logic [IDX_W-1:0]  count
);
    localparam int LB = $clog2(BYTE_W);

    typedef struct packed {
        logic [IDX_W-1:0] count;
        logic [IDX_W-1:0] lp_a;
        logic [IDX_W-1:0] lp_b;
        logic [CP_W-1:0]  cp;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [CP_W-1:0] cp_byte;

    // Mask of data bits whose index has bit g equal to h
    function automatic logic [BYTE_W-1:0] col_mask(input int g, input int h);
        logic [BYTE_W-1:0] m;
        for (int b = 0; b < BYTE_W; b++) begin
            m[b] = (((b >> g) & 1) == h);
        end
        return m;
    endfunction

    for (genvar g = 0; g < LB; g++) begin : g_col
        for (genvar h = 0; h < 2; h++) begin : g_half
            assign cp_byte[2*g+h] = ^(din & col_mask(g, h));
        end
    end

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (valid) begin
            if (^din) begin
                acc_d.lp_a = acc_q.lp_a ^ ~acc_q.count;
                acc_d.lp_b = acc_q.lp_b ^ acc_q.count;
            end
            acc_d.cp    = acc_q.cp ^ cp_byte;
            acc_d.count = acc_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign lp_a  = acc_q.lp_a;
    assign lp_b  = acc_q.lp_b;
    assign cp    = acc_q.cp;
    assign count = acc_q.count;

endmodule

// File: rtl/nfh_parity_view.sv
module nfh_parity_view #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] lp_a,
    input  logic [IDX_W-1:0] lp_b,
    output logic [IDX_W-1:0] view_hi,
    output logic [IDX_W-1:0] view_lo
);
    localparam int HALF = IDX_W / 2;

    for (genvar k = 0; k < HALF; k++) begin : g_ilv
        assign view_hi[2*k]   = lp_a[HALF+k];
        assign view_hi[2*k+1] = lp_b[HALF+k];
        assign view_lo[2*k]   = lp_a[k];
        assign view_lo[2*k+1] = lp_b[k];
    end

endmodule

// File: rtl/nfh_regif.sv
module nfh_regif
    import nfh_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              nand_ce,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_wp,
    input  logic              nand_rb,
    output logic [BYTE_W-1:0] nand_dout,
    output logic              nand_wr_stb,
    input  logic [BYTE_W-1:0] nand_din,
    output logic              nand_rd_stb
);
    localparam int HI_LSB = DATA_W / 2;
    localparam int CP_W   = 2 * $clog2(BYTE_W);

    typedef struct packed {
        nfh_state_e        state;
        logic              wide;
        logic [BYTE_W-1:0] ctl;
        logic              ack;
        logic [DATA_W-1:0] rdata;
        logic [BYTE_W-1:0] dout;
        logic              wr_stb;
    } regs_t;

    regs_t r_d, r_q;

    logic [IDX_W-1:0]  lp_a, lp_b, view_hi, view_lo, ecc_count;
    logic [CP_W-1:0]   ecc_cp;
    logic              ecc_valid, ecc_clr;
    logic [BYTE_W-1:0] ecc_byte;
    logic              accept;
    logic [DATA_W-1:0] reg_view;

    nfh_ecc_acc #(.BYTE_W(BYTE_W), .IDX_W(IDX_W), .CP_W(CP_W)) u_ecc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ecc_clr),
        .valid (ecc_valid),
        .din   (ecc_byte),
        .lp_a  (lp_a),
        .lp_b  (lp_b),
        .cp    (ecc_cp),
        .count (ecc_count)
    );

    nfh_parity_view #(.IDX_W(IDX_W)) u_view (
        .lp_a    (lp_a),
        .lp_b    (lp_b),
        .view_hi (view_hi),
        .view_lo (view_lo)
    );

    assign accept = req_valid && (r_q.state == ST_IDLE);

    // Read view of the simple registers
    always_comb begin
        reg_view = '0;
        case (int'(req_addr))
            OFS_LP_HI: reg_view[IDX_W-1:0] = view_hi;
            OFS_LP_LO: reg_view[IDX_W-1:0] = view_lo;
            OFS_COLP:  reg_view[CP_W-1:0]  = ecc_cp;
            OFS_CNT:   reg_view[IDX_W-1:0] = ecc_count;
            OFS_CTL: begin
                reg_view[BYTE_W-1:0] = r_q.ctl;
                reg_view[CTL_RB]     = nand_rb;
            end
            default:   reg_view = '0;
        endcase
    end

    always_comb begin
        r_d        = r_q;
        r_d.ack    = 1'b0;
        r_d.wr_stb = 1'b0;
        ecc_valid  = 1'b0;
        ecc_clr    = 1'b0;
        ecc_byte   = req_wdata[BYTE_W-1:0];

        case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (req_we) begin
                        r_d.ack   = 1'b1;
                        r_d.rdata = '0;
                        case (int'(req_addr))
                            OFS_CTL: begin
                                r_d.ctl         = req_wdata[BYTE_W-1:0];
                                r_d.ctl[CTL_RB] = 1'b0;
                            end
                            OFS_CLR:  ecc_clr = 1'b1;
                            OFS_DATA: begin
                                r_d.dout   = req_wdata[BYTE_W-1:0];
                                r_d.wr_stb = 1'b1;
                                ecc_valid  = 1'b1;
                            end
                            default: ;
                        endcase
                    end else if (int'(req_addr) == OFS_DATA) begin
                        r_d.state = ST_RD_FIRST;
                        r_d.wide  = req_wide;
                    end else begin
                        r_d.ack   = 1'b1;
                        r_d.rdata = reg_view;
                    end
                end
            end
            ST_RD_FIRST: begin
                ecc_valid               = 1'b1;
                ecc_byte                = nand_din;
                r_d.rdata               = '0;
                r_d.rdata[BYTE_W-1:0]   = nand_din;
                if (r_q.wide) begin
                    r_d.state = ST_RD_SECOND;
                end else begin
                    r_d.state = ST_IDLE;
                    r_d.ack   = 1'b1;
                end
            end
            ST_RD_SECOND: begin
                ecc_valid                          = 1'b1;
                ecc_byte                           = nand_din;
                r_d.rdata[HI_LSB+BYTE_W-1:HI_LSB]  = nand_din;
                r_d.state                          = ST_IDLE;
                r_d.ack                            = 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.state == ST_IDLE);
    assign rsp_valid   = r_q.ack;
    assign rsp_rdata   = r_q.rdata;
    assign nand_ce     = r_q.ctl[CTL_CE0] | r_q.ctl[CTL_CE1];
    assign nand_cle    = r_q.ctl[CTL_CLE];
    assign nand_ale    = r_q.ctl[CTL_ALE];
    assign nand_wp     = r_q.ctl[CTL_WP];
    assign nand_dout   = r_q.dout;
    assign nand_wr_stb = r_q.wr_stb;
    assign nand_rd_stb = (r_q.state != ST_IDLE);

endmodule

// File: rtl/nfh_regif_chk.sv
module nfh_regif_chk
    import nfh_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_we,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              nand_cle,
    input logic              nand_wp,
    input logic              nand_rb,
    input logic              nand_wr_stb,
    input logic              nand_rd_stb,
    input logic [IDX_W-1:0]  ecc_count
);
    logic acc_wr, acc_rd, undec;

    assign acc_wr = req_valid && req_ready && req_we;
    assign acc_rd = req_valid && req_ready && !req_we;
    assign undec  = (int'(req_addr) >= 'h1C) || (req_addr[1:0] != 2'b00)
                    || (int'(req_addr) == OFS_CLR);

    // R2: pins follow the written control value
    a_r2_cle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_wr && int'(req_addr) == OFS_CTL) |->
            (nand_cle == $past(req_wdata[CTL_CLE])) && (nand_wp == $past(req_wdata[CTL_WP])));

    // R3: ready/busy bit comes from the live pin
    a_r3_rb_live: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(acc_rd && int'(req_addr) == OFS_CTL)) |->
            (rsp_rdata[CTL_RB] == $past(nand_rb)));

    // R4: a write strobe only follows an accepted data write
    a_r4_wr_source: assert property (@(posedge clk) disable iff (!rst_n)
        nand_wr_stb |-> $past(acc_wr && int'(req_addr) == OFS_DATA));

    // R10: clear empties the accumulator
    a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_wr && int'(req_addr) == OFS_CLR) |-> (ecc_count == '0));

    // R11: undecoded reads return zero
    a_r11_undec_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(acc_rd && undec)) |-> (rsp_rdata == '0));

    // R12: no request is taken while a NAND read runs
    a_r12_busy: assert property (@(posedge clk) disable iff (!rst_n)
        nand_rd_stb |-> !req_ready);

endmodule

bind nfh_regif nfh_regif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_we      (req_we),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .nand_cle    (nand_cle),
    .nand_wp     (nand_wp),
    .nand_rb     (nand_rb),
    .nand_wr_stb (nand_wr_stb),
    .nand_rd_stb (nand_rd_stb),
    .ecc_count   (ecc_count)
);

// File: tb/sim_nfh_regif.sv
`timescale 1ns/1ps
module sim_nfh_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0, req_wide = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        nand_ce, nand_cle, nand_ale, nand_wp, nand_wr_stb, nand_rd_stb;
    logic        nand_rb = 1'b0;
    logic [7:0]  nand_dout, nand_din;

    always #4 clk = ~clk;

    nfh_regif u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .nand_ce(nand_ce), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_wp(nand_wp), .nand_rb(nand_rb), .nand_dout(nand_dout),
        .nand_wr_stb(nand_wr_stb), .nand_din(nand_din), .nand_rd_stb(nand_rd_stb)
    );

    int tests = 0, fails = 0;
    int rd_ptr = 0, wr_cnt = 0, cycles = 0;

    // Reference model state
    bit [7:0] cnt_m = 0, a_m = 0, b_m = 0, ctl_m = 0;
    bit [5:0] cp_m = 0;
    int       rp_m = 0;

    function automatic bit [7:0] nand_byte(input int i);
        return 8'((i * 37 + 11) ^ (i >> 3));
    endfunction

    assign nand_din = nand_byte(rd_ptr);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (nand_rd_stb) rd_ptr <= rd_ptr + 1;
        if (nand_wr_stb) wr_cnt <= wr_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock monitor (R12)
    always @(negedge clk) begin
        if (rst_n && nand_rd_stb) chk(!req_ready, "R12 ready during read", 32'(req_ready), 0);
        if (rst_n && nand_rd_stb && nand_wr_stb) chk(0, "R12 strobe overlap", 1, 0);
    end

    always @(negedge clk) begin
        if (cycles > 150000) begin
            fails++; tests++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic void digest(input bit [7:0] d);
        if (^d) begin
            a_m ^= ~cnt_m;
            b_m ^= cnt_m;
        end
        for (int b = 0; b < 8; b++) begin
            if (d[b]) begin
                cp_m[b & 1]              ^= 1'b1;
                cp_m[2 + ((b >> 1) & 1)] ^= 1'b1;
                cp_m[4 + ((b >> 2) & 1)] ^= 1'b1;
            end
        end
        cnt_m++;
    endfunction

    function automatic bit [7:0] ilv(input bit hi);
        bit [7:0] r;
        for (int k = 0; k < 4; k++) begin
            r[2*k]   = hi ? a_m[4+k] : a_m[k];
            r[2*k+1] = hi ? b_m[4+k] : b_m[k];
        end
        return r;
    endfunction

    task automatic access(input bit we, input bit wide, input logic [5:0] addr,
                          input logic [31:0] wd, output logic [31:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1; req_we = we; req_wide = wide; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        while (!rsp_valid && lat < 10) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        @(negedge clk);
        chk(!rsp_valid, "R12 single response", 32'(rsp_valid), 0);
    endtask

    task automatic check_ecc(input string tag);
        logic [31:0] rd; int lat;
        access(0, 0, 6'h0C, 0, rd, lat); chk(rd == 32'(cnt_m), {tag, " R7 count"}, rd, 32'(cnt_m));
        access(0, 0, 6'h00, 0, rd, lat); chk(rd == 32'(ilv(1)), {tag, " R8 parity hi"}, rd, 32'(ilv(1)));
        access(0, 0, 6'h04, 0, rd, lat); chk(rd == 32'(ilv(0)), {tag, " R8 parity lo"}, rd, 32'(ilv(0)));
        access(0, 0, 6'h08, 0, rd, lat); chk(rd == 32'(cp_m), {tag, " R9 column"}, rd, 32'(cp_m));
    endtask

    task automatic check_pins(input string tag);
        chk(nand_cle == ctl_m[1] && nand_ale == ctl_m[2] && nand_wp == ctl_m[3] &&
            nand_ce == (ctl_m[0] | ctl_m[4]), tag,
            {28'd0, nand_ce, nand_wp, nand_ale, nand_cle},
            {28'd0, ctl_m[0] | ctl_m[4], ctl_m[3], ctl_m[2], ctl_m[1]});
    endtask

    task automatic data_write(input bit [7:0] d);
        logic [31:0] rd; int lat; int w0;
        w0 = wr_cnt;
        access(1, 0, 6'h14, {24'hA5A5A5, d}, rd, lat);
        chk(lat == 1, "R4 write latency", lat, 1);
        chk(nand_dout == d, "R4 dout", 32'(nand_dout), 32'(d));
        chk(wr_cnt == w0 + 1, "R4 one strobe", wr_cnt - w0, 1);
        digest(d);
    endtask

    task automatic data_read(input bit wide);
        logic [31:0] rd, exp; int lat; int r0;
        r0 = rd_ptr;
        exp = '0;
        exp[7:0] = nand_byte(rp_m); digest(nand_byte(rp_m)); rp_m++;
        if (wide) begin
            exp[23:16] = nand_byte(rp_m); digest(nand_byte(rp_m)); rp_m++;
        end
        access(0, wide, 6'h14, 0, rd, lat);
        if (wide) begin
            chk(rd == exp, "R6 wide data", rd, exp);
            chk(lat == 3, "R6 latency", lat, 3);
            chk(rd_ptr == r0 + 2, "R6 two strobes", rd_ptr - r0, 2);
        end else begin
            chk(rd == exp, "R5 byte data", rd, exp);
            chk(lat == 2, "R5 latency", lat, 2);
            chk(rd_ptr == r0 + 1, "R5 one strobe", rd_ptr - r0, 1);
        end
    endtask

    initial begin
        logic [31:0] rd; int lat; int w0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(!nand_ce && !nand_cle && !nand_ale && !nand_wp && !nand_wr_stb && !nand_rd_stb,
            "R1 pins low", {26'd0, nand_ce, nand_cle, nand_ale, nand_wp, nand_wr_stb, nand_rd_stb}, 0);
        chk(req_ready && !rsp_valid, "R1 handshake", {30'd0, req_ready, rsp_valid}, 32'h2);
        check_ecc("R1");

        // R2 / R3
        access(1, 0, 6'h18, 32'h0000_00FF, rd, lat); ctl_m = 8'hDF;
        check_pins("R2 all set");
        nand_rb = 0;
        access(0, 0, 6'h18, 0, rd, lat); chk(rd == 32'hDF, "R3 ctl rb=0", rd, 32'hDF);
        nand_rb = 1;
        access(0, 0, 6'h18, 0, rd, lat); chk(rd == 32'hFF, "R3 ctl rb=1", rd, 32'hFF);
        access(1, 1, 6'h18, 32'hABCD_0133, rd, lat); ctl_m = 8'h13;
        check_pins("R2 cle ce0");
        access(0, 0, 6'h18, 0, rd, lat); chk(rd == 32'h33, "R3 ctl 0x13 rb=1", rd, 32'h33);
        access(1, 0, 6'h18, 32'h0000_001C, rd, lat); ctl_m = 8'h1C;
        check_pins("R2 ce1 only");
        access(1, 0, 6'h18, 32'h0000_0000, rd, lat); ctl_m = 8'h00;
        check_pins("R2 all clear");
        access(1, 0, 6'h18, 32'h0000_0005, rd, lat); ctl_m = 8'h05;

        // R4 R7 R8 R9 writes
        for (int i = 0; i < 20; i++) data_write(8'(i * 53 ^ (i >> 2)));
        data_write(8'h00);
        data_write(8'h01);
        check_ecc("writes");

        // R5 R6 reads
        for (int i = 0; i < 6; i++) data_read(0);
        for (int i = 0; i < 5; i++) data_read(1);
        check_ecc("reads");

        // R10 clear
        access(1, 1, 6'h10, 32'hFFFF_FFFF, rd, lat);
        cnt_m = 0; a_m = 0; b_m = 0; cp_m = 0;
        check_ecc("R10 after clear");
        check_pins("R10 ctl kept");
        access(0, 0, 6'h18, 0, rd, lat); chk(rd == 32'h25, "R10 ctl value kept", rd, 32'h25);

        // R11 undecoded and read-only
        data_write(8'h7E);
        w0 = wr_cnt; r0 = rd_ptr;
        access(0, 0, 6'h1C, 0, rd, lat); chk(rd == 0, "R11 read 0x1C", rd, 0);
        access(0, 1, 6'h3C, 0, rd, lat); chk(rd == 0, "R11 read 0x3C", rd, 0);
        access(0, 0, 6'h16, 0, rd, lat); chk(rd == 0, "R11 read 0x16", rd, 0);
        access(0, 0, 6'h10, 0, rd, lat); chk(rd == 0, "R11 read clear reg", rd, 0);
        access(1, 0, 6'h1C, 32'hFF, rd, lat);
        access(1, 0, 6'h19, 32'hFF, rd, lat);
        access(1, 0, 6'h12, 32'hFF, rd, lat);
        access(1, 0, 6'h00, 32'hFF, rd, lat);
        access(1, 0, 6'h0C, 32'hFF, rd, lat);
        access(1, 0, 6'h08, 32'hFF, rd, lat);
        check_pins("R11 pins unchanged");
        chk(wr_cnt == w0 && rd_ptr == r0, "R11 no strobes", wr_cnt + rd_ptr - w0 - r0, 0);
        check_ecc("R11 ecc unchanged");

        // R7 R8 wrap past 256 bytes
        for (int i = 0; i < 150; i++) data_write(8'(i * 29 + 3));
        for (int i = 0; i < 80; i++) data_read(1);
        check_ecc("wrap");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule